// File: doc/BRIEF.md
# DMA Address Translation Unit

This block sits between bus-mastering devices and main memory. Each device presents a 32-bit virtual DMA address together with its slot number and a read/write flag. The unit returns either a 31-bit physical address or a fault with a cause code. Translation covers a window that always ends at the top of the 32-bit space. The window size is set in software as a power of two from 16 MB to 2 GB.

Mappings come from a flat table of 32-bit entries in memory, one per 4 KB page. The table starts at a programmable base address. Recently used mappings are held in a small fully-associative cache, and software can clear either the whole cache or a single page. Any slot can be put into pass-through mode, where its addresses go straight to memory and a per-slot configured bit supplies physical bit 30.

Top module: `iova_xlate`

## Requirements
- R1: After reset, no response or memory read is pending and `req_ready` is high. The control word reads back with only the implementation number in bits 31:28 and the version in bits 27:24, both fixed by parameters. The base and slot words read zero.
- R2: Control word (index 0): bit 0 is the translation enable and bits 4:2 are the window size code. All other bits are ignored on write. Bits 31:24 are read-only.
- R3: A window code c covers 0xFFFFFFFF - 2^(24+c) + 1 through 0xFFFFFFFF. A translated request outside the window returns a fault with cause 1 one cycle after acceptance, and issues no memory read.
- R4: On a cache miss, exactly one entry is read from base (index 1) + ((va - window start) >> 12) * 4. In an entry, bit 1 is valid, bit 2 is writable and bits 26:8 are the physical page number. A good entry gives physical address {entry[26:8], va[11:0]}.
- R5: An entry with bit 1 clear returns a fault with cause 2 and is not cached, so a repeat of the request reads memory again.
- R6: A write to a page whose entry has bit 2 clear returns a fault with cause 3, whether the mapping came from memory or from the cache. A read of the same page succeeds.
- R7: A request that hits the cache responds one cycle after acceptance without a memory read.
- R8: The cache holds 8 entries and fills them in round-robin order. After eight distinct fills, the ninth evicts the first one.
- R9: A write of any value to the flush-all word (index 2) invalidates every cached mapping and restarts the replacement order at entry 0.
- R10: A write to the page-flush word (index 3) invalidates only the cached mapping whose page equals bits 31:12 of the written value.
- R11: When bit 0 of a slot's word (index 4 + slot) is set, that slot's requests return {word bit 16, va[29:0]} one cycle after acceptance. This holds even with translation disabled, and issues no memory read.
- R12: A slot word keeps bits 0, 1, 2 and 16 and reads the others as zero. Bits 1 and 2 are stored burst-capability flags with no effect on translation.
- R13: With translation disabled, a request from a slot that is not in pass-through returns a fault with cause 0 one cycle after acceptance.
- R14: A flush written while an entry fetch is outstanding still lets that request complete correctly, but the fetched mapping is not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | 32 | Virtual DMA address |
| req_write | input | 1 | Request is a write |
| req_slot | input | SLOT_W (2) | Requesting slot |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_cause | output | 2 | Fault cause: 0 disabled, 1 window, 2 invalid, 3 write-protect |
| rsp_paddr | output | 31 | Physical address (zero on fault) |
| mem_rd_en | output | 1 | One-cycle entry read strobe |
| mem_rd_addr | output | 32 | Entry address |
| mem_rd_valid | input | 1 | Entry data returned (at least one cycle after the strobe) |
| mem_rd_data | input | 32 | Entry data |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | CFG_AW (3) | Register word index |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_addr | input | CFG_AW (3) | Register read index |
| cfg_rd_data | output | 32 | Register read data (combinational) |

## Verification
The window edge is probed from both sides under several size codes. A design that decodes the code off by one, or that indexes from address zero instead of from the window start, either faults on valid addresses or fetches the wrong table word.

Replacement order is checked by filling nine distinct pages and then probing the second page before the first. A design that does not wrap its pointer, or that evicts the wrong way, shows a read where a hit was expected.

Page flush is sent with junk in the low 12 bits, which catches a design that compares the full address. A flush issued during an outstanding fetch catches a design that caches a mapping that was invalidated while in flight. Write protection is checked on both the fetch path and the hit path, since a design can enforce it in only one of them.

// File: rtl/iova_pkg.sv
package iova_pkg;

   localparam int VA_W       = 32;
   localparam int PA_W       = 31;
   localparam int PG_SH      = 12;
   localparam int VPN_W      = VA_W - PG_SH;
   localparam int PPN_W      = PA_W - PG_SH;
   localparam int RANGE_W    = 3;
   localparam int WIN_MIN_SH = 24;

   // register word indices
   localparam int REG_CTRL  = 0;
   localparam int REG_BASE  = 1;
   localparam int REG_FLUSH = 2;
   localparam int REG_PGFL  = 3;
   localparam int REG_SLOT0 = 4;

   // table entry fields
   localparam int PTE_VALID  = 1;
   localparam int PTE_WR     = 2;
   localparam int PTE_PPN_LO = 8;
   localparam int PTE_PPN_HI = PTE_PPN_LO + PPN_W - 1;

   typedef enum logic [1:0] {
      CAUSE_OFF     = 2'd0,
      CAUSE_WINDOW  = 2'd1,
      CAUSE_INVALID = 2'd2,
      CAUSE_WPROT   = 2'd3
   } fault_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_FETCH = 1'b1
   } xl_state_e;

   typedef struct packed {
      logic             valid;
      logic [VPN_W-1:0] vpn;
      logic [PPN_W-1:0] ppn;
      logic             wr;
   } tlb_ent_t;

endpackage

// File: rtl/iova_window.sv
module iova_window
   import iova_pkg::*;
(
   input  logic [VA_W-1:0]    addr,
   input  logic [RANGE_W-1:0] range_code,
   output logic               in_win,
   output logic [VPN_W-1:0]   tbl_idx
);

   if (WIN_MIN_SH + (1 << RANGE_W) - 1 > VA_W) begin : g_bad_range
      $error("window codes exceed the address width");
   end

   logic [VA_W-1:0] off_mask;
   logic [VA_W-1:0] off;

   always_comb begin
      off_mask = ~({VA_W{1'b1}} << (WIN_MIN_SH + 32'(range_code)));
      off      = addr & off_mask;
      in_win   = &(addr | off_mask);
      tbl_idx  = VPN_W'(off >> PG_SH);
   end

endmodule

// File: rtl/iova_regs.sv
module iova_regs
   import iova_pkg::*;
#(
   parameter int         SLOTS      = 4,
   parameter int         AW         = 3,
   parameter logic [3:0] IMPL_ID    = 4'h2,
   parameter logic [3:0] VERSION_ID = 4'h5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [AW-1:0]      rd_addr,
   output logic [31:0]        rd_data,
   output logic               xl_en,
   output logic [RANGE_W-1:0] range_code,
   output logic [VA_W-1:0]    tbl_base,
   output logic [SLOTS-1:0]   slot_byp,
   output logic [SLOTS-1:0]   slot_hi,
   output logic               flush_all,
   output logic               flush_pg,
   output logic [VPN_W-1:0]   flush_vpn
);

   if ((1 << AW) < REG_SLOT0 + SLOTS) begin : g_bad_aw
      $error("register index too narrow for slot count");
   end

   logic               en_q;
   logic [RANGE_W-1:0] range_q;
   logic [VA_W-1:0]    base_q;
   logic [SLOTS-1:0]   byp_q, b8_q, b16_q, hi_q;
   logic [31:0]        slot_word [SLOTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         range_q <= '0;
         base_q  <= '0;
         byp_q   <= '0;
         b8_q    <= '0;
         b16_q   <= '0;
         hi_q    <= '0;
      end else if (wr_en) begin
         if (wr_addr == AW'(REG_CTRL)) begin
            en_q    <= wr_data[0];
            range_q <= wr_data[4:2];
         end
         if (wr_addr == AW'(REG_BASE)) base_q <= wr_data;
         for (int s = 0; s < SLOTS; s++) begin
            if (wr_addr == AW'(REG_SLOT0 + s)) begin
               byp_q[s] <= wr_data[0];
               b8_q[s]  <= wr_data[1];
               b16_q[s] <= wr_data[2];
               hi_q[s]  <= wr_data[16];
            end
         end
      end
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot_word
      assign slot_word[s] = {15'b0, hi_q[s], 13'b0, b16_q[s], b8_q[s], byp_q[s]};
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == AW'(REG_CTRL))
         rd_data = {IMPL_ID, VERSION_ID, 19'b0, range_q, 1'b0, en_q};
      else if (rd_addr == AW'(REG_BASE))
         rd_data = base_q;
      else begin
         for (int s = 0; s < SLOTS; s++) begin
            if (rd_addr == AW'(REG_SLOT0 + s)) rd_data = slot_word[s];
         end
      end
   end

   assign xl_en      = en_q;
   assign range_code = range_q;
   assign tbl_base   = base_q;
   assign slot_byp   = byp_q;
   assign slot_hi    = hi_q;
   assign flush_all  = wr_en && (wr_addr == AW'(REG_FLUSH));
   assign flush_pg   = wr_en && (wr_addr == AW'(REG_PGFL));
   assign flush_vpn  = wr_data[VA_W-1:PG_SH];

endmodule

// File: rtl/iova_tlb.sv
module iova_tlb
   import iova_pkg::*;
#(
   parameter  int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             hit,
   output logic [PPN_W-1:0] hit_ppn,
   output logic             hit_wr,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_wr,
   input  logic             flush_all,
   input  logic             flush_pg,
   input  logic [VPN_W-1:0] flush_vpn
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cache depth must be a power of two of at least 2");
   end

   tlb_ent_t         ent_q [DEPTH];
   logic [DEPTH-1:0] hit_vec;
   logic [PTR_W-1:0] rr_q;
   logic             fill_ok;

   // a flush in the same cycle suppresses the fill
   assign fill_ok = fill_en && !flush_all && !flush_pg;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign hit_vec[i] = ent_q[i].valid && (ent_q[i].vpn == lk_vpn);

      p_pgflush_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (flush_pg && ent_q[i].valid && ent_q[i].vpn == flush_vpn) |=> !ent_q[i].valid)
         else $error("page flush left a matching entry valid");
   end

   always_comb begin
      hit     = |hit_vec;
      hit_ppn = '0;
      hit_wr  = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (hit_vec[i]) begin
            hit_ppn = hit_ppn | ent_q[i].ppn;
            hit_wr  = hit_wr | ent_q[i].wr;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
         rr_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (flush_all || (flush_pg && ent_q[i].vpn == flush_vpn))
               ent_q[i].valid <= 1'b0;
            else if (fill_ok && rr_q == PTR_W'(i))
               ent_q[i] <= '{valid: 1'b1, vpn: fill_vpn, ppn: fill_ppn, wr: fill_wr};
         end
         if (flush_all)    rr_q <= '0;
         else if (fill_ok) rr_q <= rr_q + 1'b1;
      end
   end

   p_hit_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec))
      else $error("more than one cache entry hit");

   p_flushall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> !hit)
      else $error("hit right after a flush-all");

endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
   import iova_pkg::*;
#(
   parameter  int         TLB_DEPTH  = 8,
   parameter  int         SLOTS      = 4,
   parameter  logic [3:0] IMPL_ID    = 4'h2,
   parameter  logic [3:0] VERSION_ID = 4'h5,
   localparam int         SLOT_W     = $clog2(SLOTS),
   localparam int         CFG_AW     = $clog2(REG_SLOT0 + SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [31:0]       req_addr,
   input  logic              req_write,
   input  logic [SLOT_W-1:0] req_slot,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [1:0]        rsp_cause,
   output logic [30:0]       rsp_paddr,
   output logic              mem_rd_en,
   output logic [31:0]       mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [31:0]       mem_rd_data,
   input  logic              cfg_wr_en,
   input  logic [CFG_AW-1:0] cfg_wr_addr,
   input  logic [31:0]       cfg_wr_data,
   input  logic [CFG_AW-1:0] cfg_rd_addr,
   output logic [31:0]       cfg_rd_data
);

   if (SLOTS < 2) begin : g_bad_slots
      $error("at least two slots are required");
   end

   logic               xl_en;
   logic [RANGE_W-1:0] range_code;
   logic [VA_W-1:0]    tbl_base;
   logic [SLOTS-1:0]   slot_byp, slot_hi;
   logic               flush_all, flush_pg, flush_any;
   logic [VPN_W-1:0]   flush_vpn;
   logic               in_win;
   logic [VPN_W-1:0]   tbl_idx;
   logic               tlb_hit, tlb_hit_wr;
   logic [PPN_W-1:0]   tlb_hit_ppn;
   logic               fill_en;

   xl_state_e          st_q;
   logic [VA_W-1:0]    va_q;
   logic               wr_q;
   logic               drop_q;
   logic               accept;
   logic               byp_sel, hi_sel;

   logic               nx_done, nx_fault;
   fault_e             nx_cause;
   logic [PA_W-1:0]    nx_pa;

   logic               pte_ok, pte_wr;
   logic [PPN_W-1:0]   pte_ppn;
   logic               pte_unused;

   iova_regs #(
      .SLOTS(SLOTS), .AW(CFG_AW), .IMPL_ID(IMPL_ID), .VERSION_ID(VERSION_ID)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
      .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data),
      .xl_en(xl_en), .range_code(range_code), .tbl_base(tbl_base),
      .slot_byp(slot_byp), .slot_hi(slot_hi),
      .flush_all(flush_all), .flush_pg(flush_pg), .flush_vpn(flush_vpn)
   );

   iova_window u_win (
      .addr(req_addr), .range_code(range_code),
      .in_win(in_win), .tbl_idx(tbl_idx)
   );

   iova_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(req_addr[VA_W-1:PG_SH]),
      .hit(tlb_hit), .hit_ppn(tlb_hit_ppn), .hit_wr(tlb_hit_wr),
      .fill_en(fill_en), .fill_vpn(va_q[VA_W-1:PG_SH]),
      .fill_ppn(pte_ppn), .fill_wr(pte_wr),
      .flush_all(flush_all), .flush_pg(flush_pg), .flush_vpn(flush_vpn)
   );

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign byp_sel   = slot_byp[req_slot];
   assign hi_sel    = slot_hi[req_slot];
   assign flush_any = flush_all || flush_pg;

   assign pte_ok     = mem_rd_data[PTE_VALID];
   assign pte_wr     = mem_rd_data[PTE_WR];
   assign pte_ppn    = mem_rd_data[PTE_PPN_HI:PTE_PPN_LO];
   assign pte_unused = ^{mem_rd_data[31:PTE_PPN_HI+1], mem_rd_data[PTE_PPN_LO-1:PTE_WR+1],
                         mem_rd_data[0]};

   assign fill_en = (st_q == ST_FETCH) && mem_rd_valid && pte_ok && !drop_q;

   // decision for requests that finish without a table read
   always_comb begin
      nx_done  = 1'b1;
      nx_fault = 1'b0;
      nx_cause = CAUSE_OFF;
      nx_pa    = '0;
      if (byp_sel) begin
         nx_pa = {hi_sel, req_addr[PA_W-2:0]};
      end else if (!xl_en) begin
         nx_fault = 1'b1;
         nx_cause = CAUSE_OFF;
      end else if (!in_win) begin
         nx_fault = 1'b1;
         nx_cause = CAUSE_WINDOW;
      end else if (tlb_hit) begin
         if (req_write && !tlb_hit_wr) begin
            nx_fault = 1'b1;
            nx_cause = CAUSE_WPROT;
         end else begin
            nx_pa = {tlb_hit_ppn, req_addr[PG_SH-1:0]};
         end
      end else begin
         nx_done = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         va_q        <= '0;
         wr_q        <= 1'b0;
         drop_q      <= 1'b0;
         rsp_valid   <= 1'b0;
         rsp_fault   <= 1'b0;
         rsp_cause   <= '0;
         rsp_paddr   <= '0;
         mem_rd_en   <= 1'b0;
         mem_rd_addr <= '0;
      end else begin
         rsp_valid <= 1'b0;
         mem_rd_en <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  va_q   <= req_addr;
                  wr_q   <= req_write;
                  drop_q <= 1'b0;
                  if (nx_done) begin
                     rsp_valid <= 1'b1;
                     rsp_fault <= nx_fault;
                     rsp_cause <= nx_cause;
                     rsp_paddr <= nx_pa;
                  end else begin
                     st_q        <= ST_FETCH;
                     mem_rd_en   <= 1'b1;
                     mem_rd_addr <= tbl_base + VA_W'({tbl_idx, 2'b00});
                  end
               end
            end
            ST_FETCH: begin
               if (flush_any) drop_q <= 1'b1;
               if (mem_rd_valid) begin
                  st_q      <= ST_IDLE;
                  rsp_valid <= 1'b1;
                  if (!pte_ok) begin
                     rsp_fault <= 1'b1;
                     rsp_cause <= CAUSE_INVALID;
                     rsp_paddr <= '0;
                  end else if (wr_q && !pte_wr) begin
                     rsp_fault <= 1'b1;
                     rsp_cause <= CAUSE_WPROT;
                     rsp_paddr <= '0;
                  end else begin
                     rsp_fault <= 1'b0;
                     rsp_cause <= CAUSE_OFF;
                     rsp_paddr <= {pte_ppn, va_q[PG_SH-1:0]};
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   p_disabled_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !xl_en && !byp_sel) |=> (rsp_valid && rsp_fault && rsp_cause == 2'd0))
      else $error("disabled unit did not fault");

   p_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && byp_sel) |=>
         (rsp_valid && !rsp_fault && rsp_paddr[29:0] == $past(req_addr[29:0])))
      else $error("pass-through result wrong");

   p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en)
      else $error("more than one entry read per miss");

   p_fill_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FETCH && mem_rd_valid) |=> (rsp_valid && req_ready))
      else $error("no response after entry data");

   p_quiet_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FETCH) |-> !rsp_valid)
      else $error("response during fetch");

endmodule

// File: tb/iova_xlate_test.sv
module iova_xlate_test;

   localparam logic [31:0] BASE = 32'h0010_0000;
   localparam int R_CTRL = 0, R_BASE = 1, R_FLUSH = 2, R_PGFL = 3, R_SLOT0 = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [1:0]  req_slot = '0;
   logic        rsp_valid, rsp_fault;
   logic [1:0]  rsp_cause;
   logic [30:0] rsp_paddr;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        cfg_wr_en = 1'b0;
   logic [2:0]  cfg_wr_addr = '0;
   logic [31:0] cfg_wr_data = '0;
   logic [2:0]  cfg_rd_addr = '0;
   logic [31:0] cfg_rd_data;

   int          n_chk = 0;
   int          n_fail = 0;
   int          reads = 0;
   int          mem_lat = 2;
   logic [31:0] last_rd = '0;
   logic [31:0] pt [256];

   always #4 clk = ~clk;

   iova_xlate uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_slot(req_slot),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
      .rsp_paddr(rsp_paddr),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data)
   );

   // table memory model
   initial begin
      forever begin
         @(negedge clk);
         if (mem_rd_en) begin
            reads++;
            last_rd = mem_rd_addr;
            repeat (mem_lat) @(negedge clk);
            mem_rd_valid = 1'b1;
            if (mem_rd_addr >= BASE && mem_rd_addr < BASE + 32'd1024)
               mem_rd_data = pt[(mem_rd_addr - BASE) >> 2];
            else
               mem_rd_data = 32'h0;
            @(negedge clk);
            mem_rd_valid = 1'b0;
         end
      end
   end

   function automatic logic [31:0] pte(input logic [18:0] ppn, input logic wr, input logic vld);
      return {5'b0, ppn, 1'b0, 4'b0, wr, vld, 1'b0};
   endfunction

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic wr_reg(input int idx, input logic [31:0] d);
      cfg_wr_en   = 1'b1;
      cfg_wr_addr = 3'(idx);
      cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en   = 1'b0;
   endtask

   task automatic rd_reg(input int idx, output logic [31:0] d);
      cfg_rd_addr = 3'(idx);
      #1;
      d = cfg_rd_data;
   endtask

   task automatic do_req(input logic [31:0] a, input logic w, input logic [1:0] s,
                         output logic f, output logic [1:0] c, output logic [30:0] pa,
                         output int lat, output int rd);
      int r0;
      r0 = reads;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_write = w;
      req_slot  = s;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 50) begin
         @(negedge clk);
         lat++;
      end
      f  = rsp_fault;
      c  = rsp_cause;
      pa = rsp_paddr;
      rd = reads - r0;
   endtask

   function automatic logic [31:0] pg(input int i);
      return 32'hFF00_0000 | (32'(i) << 12);
   endfunction

   logic        f;
   logic [1:0]  c;
   logic [30:0] pa;
   int          lat, rd;
   logic [31:0] d;

   task automatic t_reset;
      chk("R1 rsp_valid", 32'(rsp_valid), 0);
      chk("R1 req_ready", 32'(req_ready), 1);
      chk("R1 mem_rd_en", 32'(mem_rd_en), 0);
      rd_reg(R_CTRL, d);  chk("R1 ctrl", d, 32'h2500_0000);
      rd_reg(R_BASE, d);  chk("R1 base", d, 0);
      rd_reg(R_SLOT0, d); chk("R1 slot0", d, 0);
   endtask

   task automatic t_ctrl;
      wr_reg(R_CTRL, 32'hFFFF_FFFF);
      rd_reg(R_CTRL, d); chk("R2 ctrl all ones", d, 32'h2500_001D);
      wr_reg(R_CTRL, 32'h0000_000A);
      rd_reg(R_CTRL, d); chk("R2 ctrl code 2 off", d, 32'h2500_0008);
   endtask

   task automatic t_disabled;
      wr_reg(R_CTRL, 0);
      do_req(32'hFF00_0000, 0, 0, f, c, pa, lat, rd);
      chk("R13 fault", 32'(f), 1); chk("R13 cause", 32'(c), 0);
      chk("R13 latency", lat, 1); chk("R13 no read", rd, 0);
   endtask

   task automatic t_window;
      wr_reg(R_BASE, BASE);
      wr_reg(R_CTRL, 32'h1);
      do_req(32'hFEFF_FFFF, 0, 0, f, c, pa, lat, rd);
      chk("R3 below 16MB window", {29'b0, f, c}, 32'h5); chk("R3 no read", rd, 0);
      chk("R3 latency", lat, 1);
      wr_reg(R_CTRL, 32'h1D);
      do_req(32'h7FFF_FFFF, 0, 0, f, c, pa, lat, rd);
      chk("R3 below 2GB window", {29'b0, f, c}, 32'h5);
      wr_reg(R_CTRL, 32'h0D);
      do_req(32'hF7FF_F000, 0, 0, f, c, pa, lat, rd);
      chk("R3 below 128MB window", {29'b0, f, c}, 32'h5);
      pt[5] = pte(19'h00ABC, 1, 1);
      do_req(32'hF800_5ABC, 0, 0, f, c, pa, lat, rd);
      chk("R3 128MB start indexing", 32'(pa), 32'h00AB_CABC);
      chk("R4 entry address code 3", last_rd, BASE + 32'd20);
   endtask

   task automatic t_miss_hit;
      wr_reg(R_CTRL, 32'h1);
      wr_reg(R_FLUSH, 0);
      pt[3] = pte(19'h12345, 1, 1);
      do_req(32'hFF00_3456, 0, 0, f, c, pa, lat, rd);
      chk("R4 one read", rd, 1); chk("R4 entry address", last_rd, BASE + 32'd12);
      chk("R4 no fault", 32'(f), 0); chk("R4 paddr", 32'(pa), 32'h1234_5456);
      do_req(32'hFF00_3FFF, 1, 1, f, c, pa, lat, rd);
      chk("R7 hit latency", lat, 1); chk("R7 hit no read", rd, 0);
      chk("R7 hit paddr", 32'(pa), 32'h1234_5FFF);
   endtask

   task automatic t_invalid;
      pt[7] = pte(19'h11111, 1, 0);
      do_req(32'hFF00_7000, 0, 0, f, c, pa, lat, rd);
      chk("R5 fault cause", {29'b0, f, c}, 32'h6); chk("R5 read", rd, 1);
      do_req(32'hFF00_7000, 0, 0, f, c, pa, lat, rd);
      chk("R5 not cached", rd, 1); chk("R5 fault again", {29'b0, f, c}, 32'h6);
   endtask

   task automatic t_wprot;
      pt[8] = pte(19'h00888, 0, 1);
      do_req(32'hFF00_8010, 1, 0, f, c, pa, lat, rd);
      chk("R6 write fault on fetch", {29'b0, f, c}, 32'h7);
      do_req(32'hFF00_8010, 0, 0, f, c, pa, lat, rd);
      chk("R6 read ok", {29'b0, f, c}, 0); chk("R6 read hit", rd, 0);
      chk("R6 read paddr", 32'(pa), 32'h0088_8010);
      do_req(32'hFF00_8020, 1, 0, f, c, pa, lat, rd);
      chk("R6 write fault on hit", {29'b0, f, c}, 32'h7); chk("R6 hit path no read", rd, 0);
   endtask

   task automatic t_round_robin;
      int total;
      wr_reg(R_FLUSH, 32'h1234);
      total = 0;
      for (int i = 16; i <= 24; i++) begin
         pt[i] = pte(19'(32'h100 + i), 1, 1);
         do_req(pg(i), 0, 0, f, c, pa, lat, rd);
         total += rd;
      end
      chk("R8 nine fills", total, 9);
      do_req(pg(17), 0, 0, f, c, pa, lat, rd);
      chk("R8 second page kept", rd, 0);
      chk("R8 second page paddr", 32'(pa), {1'b0, 19'(32'h111), 12'h000});
      do_req(pg(16), 0, 0, f, c, pa, lat, rd);
      chk("R8 first page evicted", rd, 1);
   endtask

   task automatic t_flush_all;
      do_req(pg(20), 0, 0, f, c, pa, lat, rd);
      chk("R9 cached before flush", rd, 0);
      wr_reg(R_FLUSH, 32'hDEAD_BEEF);
      do_req(pg(20), 0, 0, f, c, pa, lat, rd);
      chk("R9 miss after flush", rd, 1);
      do_req(pg(21), 0, 0, f, c, pa, lat, rd);
      chk("R9 other page also gone", rd, 1);
   endtask

   task automatic t_page_flush;
      wr_reg(R_FLUSH, 0);
      pt[30] = pte(19'h3030, 1, 1);
      pt[31] = pte(19'h3131, 1, 1);
      do_req(pg(30), 0, 0, f, c, pa, lat, rd);
      do_req(pg(31), 0, 0, f, c, pa, lat, rd);
      wr_reg(R_PGFL, pg(30) | 32'hABC);
      do_req(pg(31), 0, 0, f, c, pa, lat, rd);
      chk("R10 other page kept", rd, 0);
      do_req(pg(30), 0, 0, f, c, pa, lat, rd);
      chk("R10 flushed page misses", rd, 1);
      chk("R10 refetched paddr", 32'(pa), {1'b0, 19'h3030, 12'h000});
   endtask

   task automatic t_bypass;
      wr_reg(R_CTRL, 0);
      wr_reg(R_SLOT0 + 2, 32'h0001_0001);
      do_req(32'h1234_5678, 1, 2, f, c, pa, lat, rd);
      chk("R11 hi bit set", 32'(pa), 32'h5234_5678);
      chk("R11 no fault", 32'(f), 0); chk("R11 latency", lat, 1); chk("R11 no read", rd, 0);
      wr_reg(R_SLOT0 + 1, 32'h0000_0001);
      do_req(32'hC000_0010, 0, 1, f, c, pa, lat, rd);
      chk("R11 hi bit clear", 32'(pa), 32'h0000_0010);
      do_req(32'hFF00_0000, 0, 0, f, c, pa, lat, rd);
      chk("R13 slot without bypass", {29'b0, f, c}, 32'h4);
   endtask

   task automatic t_slot_cfg;
      wr_reg(R_SLOT0 + 3, 32'hFFFF_FFFF);
      rd_reg(R_SLOT0 + 3, d); chk("R12 kept bits", d, 32'h0001_0007);
      wr_reg(R_SLOT0 + 3, 32'h0000_0006);
      rd_reg(R_SLOT0 + 3, d); chk("R12 burst flags only", d, 32'h0000_0006);
      do_req(32'hFF00_0000, 0, 3, f, c, pa, lat, rd);
      chk("R12 burst flags do not bypass", {29'b0, f, c}, 32'h4);
   endtask

   task automatic t_flush_in_flight;
      wr_reg(R_CTRL, 32'h1);
      wr_reg(R_FLUSH, 0);
      mem_lat = 4;
      pt[40] = pte(19'h4040, 1, 1);
      fork
         do_req(pg(40), 0, 0, f, c, pa, lat, rd);
         begin
            repeat (2) @(negedge clk);
            wr_reg(R_FLUSH, 32'h5);
         end
      join
      chk("R14 result still correct", 32'(pa), {1'b0, 19'h4040, 12'h000});
      chk("R14 read issued", rd, 1);
      mem_lat = 2;
      do_req(pg(40), 0, 0, f, c, pa, lat, rd);
      chk("R14 not cached", rd, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) pt[i] = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl();
      t_disabled();
      t_window();
      t_miss_hit();
      t_invalid();
      t_wprot();
      t_round_robin();
      t_flush_all();
      t_page_flush();
      t_bypass();
      t_slot_cfg();
      t_flush_in_flight();
      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule